// File: doc/BRIEF.md
# Interval Timers with Timer-Driven Key-On Control

This block holds two interval timers for a sound synthesis channel group. Each timer has a sticky overflow flag, and the two flags together drive one interrupt line. Timer A also drives an automatic key-on for one channel. When the channel-3 mode selects timer-driven keying, each overflow of timer A raises a one-shot key request. That request is combined with the four manual operator key bits.

Key state is sampled once per sample cycle, when `tick` is high. For each operator the block holds the effective key level. It raises a one-cycle key-on or key-off event only when that level differs from the previous sample. The envelope and phase logic downstream use a key-on event to restart the envelope and to clear the operator's phase counter. Because the automatic request is ORed with the manual bits, a timer that overflows on every sample holds the note on. Control can also pass between manual and timer-driven keying without a key-off.

Top module: `fm_timer_keyctl`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after reset, `irq`, `status`, `key_lvl`, `key_on_ev` and `key_off_ev` are all zero.
- R2: Timer A is a 10-bit up-counter that advances on each `tick` while its run bit is high. From load value L it overflows on the (1024-L)-th tick and reloads L. L = 0x3FF overflows on every tick.
- R3: Timer B is an 8-bit up-counter that advances once every 16 ticks while its run bit is high. From load value L it overflows on the 16*(256-L)-th tick and then reloads L.
- R4: An overflow sets that timer's flag one cycle later, but only if the timer's flag-enable bit is high. A set flag stays set until its clear input is pulsed. If an overflow and a clear arrive in the same cycle, the flag is set.
- R5: `status[0]` is the timer A flag and `status[1]` is the timer B flag. `irq` is their OR in the same cycle.
- R6: While a timer's run bit is low, its count and prescaler are frozen. In the cycle after the run bit rises, the counter holds the load value and the prescaler is zero. No counting takes place in that cycle.
- R7: Automatic keying is selected only by `ch3_mode` = 2'b10. Values 00, 01 and 11 leave it off. A timer A overflow sets the automatic key request whether or not timer A's flag-enable bit is high.
- R8: On each tick, `key_lvl[i]` becomes `man_key[i]` ORed with the automatic request. The request is consumed by that evaluation and stays set only if timer A overflows on the same tick. Between ticks, `key_lvl` does not change.
- R9: When `ch3_mode` is not 2'b10, the automatic request is cleared and contributes nothing at the next evaluation. An operator held only by the request then goes to key-off.
- R10: `key_on_ev[i]` and `key_off_ev[i]` are one-cycle pulses, asserted together with the `key_lvl` update, and only when bit i changes. A key-on event is also the phase-counter clear request for that operator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pulse per sample cycle |
| ta_load | input | 10 | Timer A reload value |
| tb_load | input | 8 | Timer B reload value |
| ta_run | input | 1 | Timer A run bit; rising edge loads the counter |
| tb_run | input | 1 | Timer B run bit; rising edge loads the counter |
| ta_irq_en | input | 1 | Timer A flag enable |
| tb_irq_en | input | 1 | Timer B flag enable |
| ta_clr | input | 1 | Timer A flag clear pulse |
| tb_clr | input | 1 | Timer B flag clear pulse |
| ch3_mode | input | 2 | Channel-3 mode; 2'b10 selects timer-driven keying |
| man_key | input | 4 | Manual key bits, one per operator |
| irq | output | 1 | Interrupt, OR of both flags |
| status | output | 2 | {timer B flag, timer A flag} |
| key_lvl | output | 4 | Effective key level per operator |
| key_on_ev | output | 4 | Key-on event pulses; also phase clear requests |
| key_off_ev | output | 4 | Key-off event pulses |

## Verification
Timer A is run from load value 0x3FF in mode 10, so it overflows on every tick. The bench checks that the key rises once and is then held, with no further events. A design that cleared the request before it re-armed would toggle key-off and key-on on every sample. The mode is then switched to 11, which must give exactly one key-off; a design that accepted either top-bit mode would keep the note held. Other cases target the edge of the flag enable, the clear arriving together with an overflow, the 16-tick prescaler of timer B, and the load taken on the rising run bit. The last case hands a held key from the timer over to the manual bits, where an OR placed after the event detector would emit spurious pulses.

// File: rtl/fmtk_pkg.sv
package fmtk_pkg;
  localparam int NUM_OP    = 4;
  localparam int TA_WIDTH  = 10;
  localparam int TB_WIDTH  = 8;
  localparam int TB_PRE_W  = 4;
  localparam int MODE_W    = 2;
  typedef logic [MODE_W-1:0] ch3_mode_t;
  localparam ch3_mode_t MODE_AUTO_KEY = 2'b10;
endpackage

// File: rtl/fmtk_timer.sv
module fmtk_timer #(
  parameter int CNT_W = 10,
  parameter int PRE_W = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  input  logic [CNT_W-1:0] load_val,
  input  logic             flag_en,
  input  logic             flag_clr,
  output logic             ovf,
  output logic             flag
);
  localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

  logic             run_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             flag_q, flag_d;
  logic             start, active, step;

  assign start  = run & ~run_q;
  assign active = run & run_q;

  generate
    if (PRE_W == 0) begin : g_no_pre
      assign step = tick;
    end else begin : g_pre
      localparam logic [PRE_W-1:0] PRE_TOP = {PRE_W{1'b1}};
      logic [PRE_W-1:0] pre_q, pre_d;
      always_comb begin
        pre_d = pre_q;
        if (start)              pre_d = '0;
        else if (active & tick) pre_d = pre_q + 1'b1;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
      end
      assign step = tick & (pre_q == PRE_TOP);
    end
  endgenerate

  assign ovf = active & step & (cnt_q == CNT_TOP);

  always_comb begin
    cnt_d = cnt_q;
    if (start)              cnt_d = load_val;
    else if (active & step) cnt_d = ovf ? load_val : cnt_q + 1'b1;
    flag_d = flag_q;
    if (ovf & flag_en)      flag_d = 1'b1;
    else if (flag_clr)      flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      run_q  <= run;
      cnt_q  <= cnt_d;
      flag_q <= flag_d;
    end
  end

  assign flag = flag_q;

  p_flag_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !flag_clr) |=> flag_q);
  p_flag_needs_en_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(flag_en));
  p_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !ovf) |=> $stable(cnt_q));
endmodule

// File: rtl/fmtk_keyctl.sv
module fmtk_keyctl
  import fmtk_pkg::*;
#(
  parameter int NOP = NUM_OP
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick,
  input  logic           ovf_a,
  input  ch3_mode_t      mode,
  input  logic [NOP-1:0] man_key,
  output logic [NOP-1:0] key_lvl,
  output logic [NOP-1:0] key_on_ev,
  output logic [NOP-1:0] key_off_ev
);
  logic           auto_sel;
  logic           req_q, req_d;
  logic [NOP-1:0] lvl_q, lvl_d, lvl_new, on_q, on_d, off_q, off_d;

  assign auto_sel = (mode == MODE_AUTO_KEY);
  assign lvl_new  = man_key | {NOP{req_q & auto_sel}};

  always_comb begin
    req_d = req_q;
    if (!auto_sel)  req_d = 1'b0;
    else if (tick)  req_d = ovf_a;
    else if (ovf_a) req_d = 1'b1;
    lvl_d = lvl_q;
    on_d  = '0;
    off_d = '0;
    if (tick) begin
      lvl_d = lvl_new;
      on_d  = lvl_new & ~lvl_q;
      off_d = ~lvl_new & lvl_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      lvl_q <= '0;
      on_q  <= '0;
      off_q <= '0;
    end else begin
      req_q <= req_d;
      lvl_q <= lvl_d;
      on_q  <= on_d;
      off_q <= off_d;
    end
  end

  assign key_lvl    = lvl_q;
  assign key_on_ev  = on_q;
  assign key_off_ev = off_q;

  p_lvl_on_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_q != $past(lvl_q)) |-> $past(tick));
  p_req_mode_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |-> $past(auto_sel));
  p_evt_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (|(on_q | off_q)) |-> $past(tick));
  p_on_sets_lvl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((on_q & ~lvl_q) == '0) && ((off_q & lvl_q) == '0));
endmodule

// File: rtl/fm_timer_keyctl.sv
module fm_timer_keyctl
  import fmtk_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic [TA_WIDTH-1:0] ta_load,
  input  logic [TB_WIDTH-1:0] tb_load,
  input  logic                ta_run,
  input  logic                tb_run,
  input  logic                ta_irq_en,
  input  logic                tb_irq_en,
  input  logic                ta_clr,
  input  logic                tb_clr,
  input  logic [MODE_W-1:0]   ch3_mode,
  input  logic [NUM_OP-1:0]   man_key,
  output logic                irq,
  output logic [1:0]          status,
  output logic [NUM_OP-1:0]   key_lvl,
  output logic [NUM_OP-1:0]   key_on_ev,
  output logic [NUM_OP-1:0]   key_off_ev
);
  logic ta_ovf, tb_ovf, ta_flag, tb_flag;

  fmtk_timer #(.CNT_W(TA_WIDTH), .PRE_W(0)) u_ta (
    .clk(clk), .rst_n(rst_n), .tick(tick), .run(ta_run), .load_val(ta_load),
    .flag_en(ta_irq_en), .flag_clr(ta_clr), .ovf(ta_ovf), .flag(ta_flag));

  fmtk_timer #(.CNT_W(TB_WIDTH), .PRE_W(TB_PRE_W)) u_tb (
    .clk(clk), .rst_n(rst_n), .tick(tick), .run(tb_run), .load_val(tb_load),
    .flag_en(tb_irq_en), .flag_clr(tb_clr), .ovf(tb_ovf), .flag(tb_flag));

  fmtk_keyctl #(.NOP(NUM_OP)) u_key (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ovf_a(ta_ovf), .mode(ch3_mode),
    .man_key(man_key), .key_lvl(key_lvl), .key_on_ev(key_on_ev),
    .key_off_ev(key_off_ev));

  assign status = {tb_flag, ta_flag};
  assign irq    = ta_flag | tb_flag;

  p_a_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ta_ovf && ta_irq_en) |=> status[0]);
  p_b_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tb_ovf && tb_irq_en) |=> status[1]);
  p_tick_ovf_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ta_ovf |-> tick);
endmodule

// File: tb/sim_fm_timer_keyctl.sv
module sim_fm_timer_keyctl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic [9:0] ta_load = '0;
  logic [7:0] tb_load = '0;
  logic ta_run = 0, tb_run = 0, ta_irq_en = 0, tb_irq_en = 0, ta_clr = 0, tb_clr = 0;
  logic [1:0] ch3_mode = 2'b00;
  logic [3:0] man_key = '0;
  logic irq;
  logic [1:0] status;
  logic [3:0] key_lvl, key_on_ev, key_off_ev;

  int errors = 0;
  int checks = 0;
  string cur_req = "R1";
  bit done = 0;

  // behavioural reference state
  int ca, cb, pb, fa, fb, req, lvl, on_e, off_e;
  bit ra_prev, rb_prev;

  fm_timer_keyctl u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ta_load(ta_load), .tb_load(tb_load),
    .ta_run(ta_run), .tb_run(tb_run), .ta_irq_en(ta_irq_en), .tb_irq_en(tb_irq_en),
    .ta_clr(ta_clr), .tb_clr(tb_clr), .ch3_mode(ch3_mode), .man_key(man_key),
    .irq(irq), .status(status), .key_lvl(key_lvl), .key_on_ev(key_on_ev),
    .key_off_ev(key_off_ev));

  always #10 clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ca = 0; cb = 0; pb = 0; fa = 0; fb = 0; req = 0; lvl = 0; on_e = 0; off_e = 0;
      ra_prev = 0; rb_prev = 0;
    end else begin
      bit oa, ob, sel;
      int nl;
      oa = ta_run && ra_prev && tick && (ca == 1023);
      ob = tb_run && rb_prev && tick && (pb == 15) && (cb == 255);
      if (ta_run && !ra_prev) ca = ta_load;
      else if (ta_run && tick) ca = oa ? ta_load : ca + 1;
      if (tb_run && !rb_prev) begin cb = tb_load; pb = 0; end
      else if (tb_run && tick) begin
        if (pb == 15) cb = ob ? tb_load : cb + 1;
        pb = (pb + 1) % 16;
      end
      ra_prev = ta_run; rb_prev = tb_run;
      if (oa && ta_irq_en) fa = 1; else if (ta_clr) fa = 0;
      if (ob && tb_irq_en) fb = 1; else if (tb_clr) fb = 0;
      sel = (ch3_mode == 2'b10);
      nl = man_key | ((req && sel) ? 15 : 0);
      if (tick) begin
        on_e = nl & ~lvl & 15; off_e = ~nl & lvl & 15; lvl = nl;
      end else begin
        on_e = 0; off_e = 0;
      end
      if (!sel) req = 0; else if (tick) req = oa; else if (oa) req = 1;
    end
  end

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s act=%0d exp=%0d t=%0t", cur_req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (!done) begin
    chk("status", status, fb * 2 + fa);
    chk("irq", irq, fa | fb);
    chk("key_lvl", key_lvl, lvl);
    chk("key_on_ev", key_on_ev, on_e);
    chk("key_off_ev", key_off_ev, off_e);
  end

  task automatic run_cycles(int n, int div);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); #1;
      tick = (div > 0) && (k % div == 0);
    end
    @(negedge clk); #1; tick = 0;
  endtask

  task automatic pulse_clr();
    @(negedge clk); #1; ta_clr = 1; tb_clr = 1;
    @(negedge clk); #1; ta_clr = 0; tb_clr = 0;
  endtask

  initial begin
    #5000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    cur_req = "R1";
    repeat (3) @(negedge clk);
    chk("reset outputs", {irq, status, key_lvl, key_on_ev, key_off_ev}, 0);
    #1 rst_n = 1;
    run_cycles(4, 0);
    // timer A period from load 1020, tick every 2 cycles
    cur_req = "R2";
    ta_load = 10'd1020; ta_irq_en = 1; ta_run = 1;
    run_cycles(30, 2);
    chk("timer A flag after overflow", status[0], 1);
    // clear, then flag enable low must not set flag
    cur_req = "R4";
    pulse_clr();
    ta_irq_en = 0;
    run_cycles(20, 1);
    chk("flag stays clear when disabled", status[0], 0);
    ta_irq_en = 1;
    run_cycles(6, 1);
    @(negedge clk); #1; ta_clr = 1; tick = 1;
    @(negedge clk); #1; ta_clr = 0; tick = 0;
    // run low freezes, rising run reloads
    cur_req = "R6";
    pulse_clr();
    ta_run = 0; ta_load = 10'd1022;
    run_cycles(10, 1);
    ta_run = 1;
    run_cycles(12, 1);
    // timer B with prescaler
    cur_req = "R3";
    ta_run = 0; pulse_clr();
    tb_load = 8'd254; tb_irq_en = 1; tb_run = 1;
    run_cycles(120, 1);
    chk("timer B flag", status[1], 1);
    cur_req = "R5";
    chk("irq follows B flag", irq, 1);
    pulse_clr();
    tb_run = 0;
    // automatic keying held by every-tick overflow
    cur_req = "R7";
    ta_irq_en = 0; ta_load = 10'h3FF; ch3_mode = 2'b10; ta_run = 1;
    run_cycles(20, 1);
    chk("held key under auto keying", key_lvl, 15);
    chk("flag enable low leaves flag clear", status[0], 0);
    cur_req = "R9";
    ch3_mode = 2'b11;
    run_cycles(6, 1);
    chk("mode 11 gives key-off", key_lvl, 0);
    // slower overflow: request consumed after one tick
    cur_req = "R8";
    ch3_mode = 2'b10; ta_run = 0; ta_load = 10'd1021;
    run_cycles(2, 0);
    ta_run = 1;
    run_cycles(30, 3);
    // handover from auto to manual keying, manual patterns
    cur_req = "R10";
    ta_load = 10'h3FF; ta_run = 0;
    run_cycles(2, 0);
    ta_run = 1;
    run_cycles(6, 1);
    man_key = 4'b1111;
    run_cycles(4, 1);
    ta_run = 0;
    run_cycles(8, 1);
    chk("handover keeps key", key_lvl, 15);
    man_key = 4'b0101;
    run_cycles(7, 3);
    man_key = 4'b1010;
    run_cycles(7, 3);
    ch3_mode = 2'b01; man_key = 4'b0000;
    run_cycles(7, 3);
    chk("all keys off", key_lvl, 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule